// File: doc/BRIEF.md
# IR Receive Run-Length Sampler

This block takes a demodulated infrared receiver signal, samples it at a selectable fixed period and turns the pulse/space waveform into a stream of run-length bytes. Each byte packs the level in its top bit and the number of sample periods at that level in the low seven bits. A long run is split into continuation bytes. A packet closes with an end byte once the line has stayed in the space state for a programmable number of samples. The bytes are stored in a 32-entry receive FIFO.

A host reads the bytes through a small register file with a read strobe and a write strobe. The same register file holds a count of stored bytes, an interrupt status register whose bits are cleared by writing one, a matching interrupt enable register, the 16-bit end-of-packet limit, a FIFO threshold and a FIFO flush control. The interrupt output is asserted while any enabled status bit is set. The input is synchronized inside the block and may be inverted for receivers whose active level is low.

Top module: `ir_rx_sampler`

## Requirements
- R1: Register map (3-bit address): 0 control, 1 status, 2 interrupt enable, 3 limit high byte, 4 limit low byte, 5 FIFO control, 6 FIFO count (read only), 7 FIFO data (read only; a read strobe removes the head byte; an empty FIFO reads 0x00). Bytes are returned in the order they were produced. A packet starts at the first sample at the pulse level. Each later level change pushes one byte for the run that ended: bit 7 is 1 for a pulse and 0 for a space, and bits 6:0 hold the run length in samples.
- R2: When a run already counts 127 samples and one more sample of the same level arrives, the byte {level, 0x7F} is pushed and counting restarts at 1. The remainder byte follows at the next level change.
- R3: In a space, when the number of space samples reaches the limit {reg3, reg4}, the end byte 0x80 is pushed instead of the pending space byte, the packet closes and status bit 5 is set. Limit values 0 and 1 disable the end byte.
- R4: Control bit 1 inverts the input, so that a low input is sampled as a pulse.
- R5: Control bits 3:2 select the sample period: 0 = 1 us, 1 = 25 us, 2 = 50 us, 3 = 100 us. The period in clocks is the number of microseconds times TICKS_PER_US.
- R6: Status bit layout: 7 data ready (set on every pushed or dropped byte), 6 threshold reached, 5 packet end, 4 overrun; bits 3:0 always read 0. Writing 1 to a bit clears only that bit. A set event in the same cycle wins over the clear.
- R7: A byte that arrives while the FIFO holds 32 bytes is dropped, the stored bytes are kept, and status bits 4 and 7 are set.
- R8: Status bit 6 is set when a push brings the FIFO count to the threshold in FIFO control bits 5:0.
- R9: Writing FIFO control with bit 7 set empties the FIFO. The bit is not stored.
- R10: The interrupt output is 1 exactly when some status bit and its enable bit in register 2 are both 1.
- R11: While control bit 0 (receive enable) is 0, no byte is produced. Enabling starts from an idle encoder.
- R12: Reset values: control 0x08 (disabled, not inverted, 50 us), status 0x00, enable 0x00, limit 0x0100, FIFO control 0x10, count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_in | input | 1 | Demodulated IR receiver signal, asynchronous |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; pops the FIFO at address 7 |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt request |

## Verification
An input edge passes two synchronizer flops and reaches the encoder on the third cycle. The byte, the FIFO count, the status bits and the interrupt all update on that third edge. Register writes take effect on the edge of the write strobe, so the interrupt output follows an enable or clear write one cycle later, and a read strobe pops the FIFO on its own edge. The bench drives each run for an exact number of cycles so that the sample counts are fixed, and it waits at least eight cycles after the last input change before it reads anything. It samples read data 1 ns after the falling edge of the strobe cycle.

// File: rtl/ir_rx_pkg.sv
// Shared constants of the IR run-length sampler: register addresses,
// status bit positions and the special byte codes.
package ir_rx_pkg;
    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] A_STAT   = 3'd1;
    localparam logic [REG_AW-1:0] A_IEN    = 3'd2;
    localparam logic [REG_AW-1:0] A_LIM_HI = 3'd3;
    localparam logic [REG_AW-1:0] A_LIM_LO = 3'd4;
    localparam logic [REG_AW-1:0] A_FCTL   = 3'd5;
    localparam logic [REG_AW-1:0] A_FCNT   = 3'd6;
    localparam logic [REG_AW-1:0] A_FDATA  = 3'd7;

    localparam int ST_RDY = 7;
    localparam int ST_THR = 6;
    localparam int ST_END = 5;
    localparam int ST_OVR = 4;

    localparam int RUN_W = 7;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;
    localparam logic [7:0] END_CODE = 8'h80;
endpackage

// File: rtl/ir_rx_sync.sv
// Multi-flop synchronizer for the asynchronous IR input.
// Assumes the input is slow compared with the clock.
module ir_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    // shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/ir_rx_tick.sv
// Sample strobe generator: one-cycle tick every selected period.
// Assumes TICKS_PER_US clocks per microsecond; restarts when disabled.
module ir_rx_tick #(
    parameter int TICKS_PER_US = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int CNT_W = $clog2(100 * TICKS_PER_US + 1);
    localparam logic [CNT_W-1:0] LIM_1   = CNT_W'(1 * TICKS_PER_US - 1);
    localparam logic [CNT_W-1:0] LIM_25  = CNT_W'(25 * TICKS_PER_US - 1);
    localparam logic [CNT_W-1:0] LIM_50  = CNT_W'(50 * TICKS_PER_US - 1);
    localparam logic [CNT_W-1:0] LIM_100 = CNT_W'(100 * TICKS_PER_US - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // decode the period select into a terminal count
    always_comb begin
        unique case (sel)
            2'd0:    lim = LIM_1;
            2'd1:    lim = LIM_25;
            2'd2:    lim = LIM_50;
            default: lim = LIM_100;
        endcase
    end

    assign tick = en && (cnt_q >= lim);

    // free-running period counter, cleared while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ir_rx_rle.sv
// Run-length encoder: turns level samples into {level, count} bytes,
// splits long runs with 0x7F-count bytes and closes a packet with the
// end byte when the space run reaches the limit. Assumes at most one
// push per tick; push and data are combinational in the tick cycle.
module ir_rx_rle
    import ir_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        tick,
    input  logic        sample,
    input  logic [15:0] limit,
    output logic        push,
    output logic [7:0]  push_data
);
    logic             active_q, active_d;
    logic             lvl_q, lvl_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [15:0]      idle_q, idle_d;
    logic             end_hit;

    assign end_hit = (limit > 16'd1) && (({1'b0, idle_q} + 17'd1) == {1'b0, limit});

    // next-state and byte emission for one sample
    always_comb begin
        active_d  = active_q;
        lvl_d     = lvl_q;
        run_d     = run_q;
        idle_d    = idle_q;
        push      = 1'b0;
        push_data = 8'h00;
        if (tick && active_q) begin
            if (sample != lvl_q) begin
                push      = 1'b1;
                push_data = {lvl_q, run_q};
                lvl_d     = sample;
                run_d     = RUN_W'(1);
                idle_d    = sample ? 16'd0 : 16'd1;
            end else if (!lvl_q && end_hit) begin
                push      = 1'b1;
                push_data = END_CODE;
                active_d  = 1'b0;
                run_d     = '0;
                idle_d    = '0;
            end else begin
                if (run_q == RUN_MAX) begin
                    push      = 1'b1;
                    push_data = {lvl_q, RUN_MAX};
                    run_d     = RUN_W'(1);
                end else begin
                    run_d = run_q + 1'b1;
                end
                if (!lvl_q && idle_q != 16'hFFFF) idle_d = idle_q + 16'd1;
            end
        end else if (tick && sample) begin
            active_d = 1'b1;
            lvl_d    = 1'b1;
            run_d    = RUN_W'(1);
            idle_d   = '0;
        end
    end

    // encoder state, held idle while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            active_q <= 1'b0;
            lvl_q    <= 1'b0;
            run_q    <= '0;
            idle_q   <= '0;
        end else begin
            active_q <= active_d;
            lvl_q    <= lvl_d;
            run_q    <= run_d;
            idle_q   <= idle_d;
        end
    end
endmodule

// File: rtl/ir_rx_fifo.sv
// Receive FIFO with occupancy count and synchronous flush.
// Assumes DEPTH is a power of two; a push is accepted when not full
// or when a pop happens in the same cycle.
module ir_rx_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_pop, do_push;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem_q[rp_q];
    assign count   = cnt_q;

    // storage write
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[wp_q] <= wdata;
    end

    // pointer and count bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ir_rx_sampler.sv
// IR receive run-length sampler top: synchronizer, period tick,
// encoder, receive FIFO and the host register file with status,
// enable and interrupt. Assumes single-cycle read and write strobes.
module ir_rx_sampler
    import ir_rx_pkg::*;
#(
    parameter int TICKS_PER_US = 250,
    parameter int FIFO_DEPTH   = 32,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic          ctrl_en, ctrl_inv;
    logic [1:0]    ctrl_sel;
    logic [7:4]    sts_q;
    logic [7:0]    ien_q;
    logic [15:0]   lim_q;
    logic [CW-1:0] thr_q;
    logic [7:0]    status_rd;

    logic          ir_sync, tick, rle_push;
    logic [7:0]    rle_data;
    logic          fifo_clr, fifo_pop, fifo_full, fifo_empty;
    logic [7:0]    fifo_rdata;
    logic [CW-1:0] fifo_cnt;
    logic          pop_eff, accept, ovr_ev, thr_ev, end_ev;
    logic [7:4]    sts_set;

    ir_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(ir_in), .dout(ir_sync)
    );

    ir_rx_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .sel(ctrl_sel), .tick(tick)
    );

    ir_rx_rle u_rle (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(tick),
        .sample(ir_sync ^ ctrl_inv), .limit(lim_q),
        .push(rle_push), .push_data(rle_data)
    );

    ir_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(rle_push), .wdata(rle_data), .pop(fifo_pop),
        .rdata(fifo_rdata), .count(fifo_cnt),
        .full(fifo_full), .empty(fifo_empty)
    );

    assign fifo_clr = reg_wr && (reg_addr == A_FCTL) && reg_wdata[7];
    assign fifo_pop = reg_rd && (reg_addr == A_FDATA);
    assign pop_eff  = fifo_pop && !fifo_empty;
    assign accept   = rle_push && !fifo_clr && (!fifo_full || pop_eff);
    assign ovr_ev   = rle_push && !fifo_clr && fifo_full && !pop_eff;
    assign thr_ev   = accept && !pop_eff && ((fifo_cnt + 1'b1) == thr_q);
    assign end_ev   = rle_push && (rle_data == END_CODE);

    // collect the status set events in register bit order
    always_comb begin
        sts_set         = '0;
        sts_set[ST_RDY] = accept || ovr_ev;
        sts_set[ST_THR] = thr_ev;
        sts_set[ST_END] = end_ev;
        sts_set[ST_OVR] = ovr_ev;
    end

    // control, enable, limit and threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_inv <= 1'b0;
            ctrl_sel <= 2'd2;
            ien_q    <= '0;
            lim_q    <= 16'h0100;
            thr_q    <= CW'(16);
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: begin
                    ctrl_en  <= reg_wdata[0];
                    ctrl_inv <= reg_wdata[1];
                    ctrl_sel <= reg_wdata[3:2];
                end
                A_IEN:    ien_q        <= reg_wdata;
                A_LIM_HI: lim_q[15:8]  <= reg_wdata;
                A_LIM_LO: lim_q[7:0]   <= reg_wdata;
                A_FCTL:   thr_q        <= reg_wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    // status bits: write-one-to-clear, set events take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else if (reg_wr && reg_addr == A_STAT) begin
            sts_q <= (sts_q & ~reg_wdata[7:4]) | sts_set;
        end else begin
            sts_q <= sts_q | sts_set;
        end
    end

    assign status_rd = {sts_q, 4'b0000};
    assign irq       = |(status_rd & ien_q);

    // read data mux
    always_comb begin
        unique case (reg_addr)
            A_CTRL:   reg_rdata = {4'b0000, ctrl_sel, ctrl_inv, ctrl_en};
            A_STAT:   reg_rdata = status_rd;
            A_IEN:    reg_rdata = ien_q;
            A_LIM_HI: reg_rdata = lim_q[15:8];
            A_LIM_LO: reg_rdata = lim_q[7:0];
            A_FCTL:   reg_rdata = 8'(thr_q);
            A_FCNT:   reg_rdata = 8'(fifo_cnt);
            default:  reg_rdata = fifo_empty ? 8'h00 : fifo_rdata;
        endcase
    end
endmodule

// Checker for the sampler: FIFO bounds, status causality, flush,
// disable and interrupt masking.
module ir_rx_sampler_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic [7:0]    ien,
    input logic [7:0]    sts,
    input logic [CW-1:0] cnt,
    input logic          push,
    input logic [7:0]    pdata,
    input logic          en,
    input logic          clr
);
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R7
    AST_OVR_READY: assert property (@(posedge clk) disable iff (!rst_n) $rose(sts[4]) |-> sts[7]); // R7
    AST_END_PE: assert property (@(posedge clk) disable iff (!rst_n) (push && pdata == 8'h80) |=> sts[5]); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (cnt == '0)); // R9
    AST_OFF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !push); // R11
    AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (ien == 8'h00) |-> !irq); // R10
endmodule

bind ir_rx_sampler ir_rx_sampler_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ien(ien_q), .sts(status_rd),
    .cnt(fifo_cnt), .push(rle_push), .pdata(rle_data), .en(ctrl_en),
    .clr(fifo_clr)
);

// File: tb/sim_ir_rx_sampler.sv
module sim_ir_rx_sampler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    ir_rx_sampler #(.TICKS_PER_US(1)) u0 (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input int exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, int'(v), exp);
    endtask

    task automatic level(input logic v, input int n);
        ir_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_limit(input int lim);
        wr(3'd3, 8'(lim >> 8));
        wr(3'd4, 8'(lim));
    endtask

    task automatic tidy(input int thr);
        wr(3'd0, 8'h00);
        ir_in = 1'b0;
        wr(3'd5, 8'h80 | 8'(thr));
        wr(3'd1, 8'hFF);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk_reg("R12 ctrl reset (R5 50us default)", 3'd0, 8'h08);
        chk_reg("R12 status reset", 3'd1, 8'h00);
        chk_reg("R12 enable reset", 3'd2, 8'h00);
        chk_reg("R12 limit hi reset", 3'd3, 8'h01);
        chk_reg("R12 limit lo reset", 3'd4, 8'h00);
        chk_reg("R12 fifo ctrl reset", 3'd5, 8'h10);
        chk_reg("R12 count reset", 3'd6, 0);
        chk_reg("R1 empty data reads 0", 3'd7, 0);
        chk("R12 irq reset", int'(irq), 0);
    endtask

    task automatic t_basic;
        set_limit(20);
        wr(3'd5, 8'd32);
        wr(3'd0, 8'h01);
        @(negedge clk);
        level(1, 5); level(0, 3); level(1, 130); level(0, 40);
        chk_reg("R1 count", 3'd6, 5);
        chk_reg("R1 pulse byte", 3'd7, 8'h85);
        chk_reg("R1 space byte", 3'd7, 8'h03);
        chk_reg("R2 continuation", 3'd7, 8'hFF);
        chk_reg("R2 remainder", 3'd7, 8'h83);
        chk_reg("R3 end byte", 3'd7, 8'h80);
        chk_reg("R6 status ready+end", 3'd1, 8'hA0);
        wr(3'd1, 8'h20);
        chk_reg("R6 w1c end only", 3'd1, 8'h80);
        wr(3'd1, 8'h80);
        chk_reg("R6 w1c ready", 3'd1, 8'h00);
        tidy(32);
    endtask

    task automatic t_long_space;
        set_limit(300);
        wr(3'd0, 8'h01);
        @(negedge clk);
        level(1, 2); level(0, 320);
        chk_reg("R2 long space count", 3'd6, 4);
        chk_reg("R2 pulse", 3'd7, 8'h82);
        chk_reg("R2 space cont 1", 3'd7, 8'h7F);
        chk_reg("R2 space cont 2", 3'd7, 8'h7F);
        chk_reg("R3 end after 300", 3'd7, 8'h80);
        tidy(32);
    endtask

    task automatic t_no_limit;
        set_limit(1);
        wr(3'd0, 8'h01);
        @(negedge clk);
        level(1, 3); level(0, 200);
        chk_reg("R3 limit 1 count", 3'd6, 2);
        chk_reg("R3 limit 1 pulse", 3'd7, 8'h83);
        chk_reg("R3 limit 1 cont", 3'd7, 8'h7F);
        chk_reg("R3 limit 1 no end flag", 3'd1, 8'h80);
        tidy(32);
    endtask

    task automatic t_invert;
        set_limit(20);
        ir_in = 1'b1;
        repeat (4) @(negedge clk);
        wr(3'd0, 8'h03);
        @(negedge clk);
        level(0, 6); level(1, 40);
        chk_reg("R4 inverted count", 3'd6, 2);
        chk_reg("R4 inverted pulse", 3'd7, 8'h86);
        chk_reg("R4 inverted end", 3'd7, 8'h80);
        tidy(32);
    endtask

    task automatic t_period;
        set_limit(4);
        wr(3'd0, 8'h05);
        @(negedge clk);
        level(1, 250); level(0, 300);
        chk_reg("R5 25us count", 3'd6, 2);
        chk_reg("R5 25us pulse of 10", 3'd7, 8'h8A);
        chk_reg("R5 25us end", 3'd7, 8'h80);
        tidy(32);
    endtask

    task automatic t_disabled;
        set_limit(4);
        wr(3'd0, 8'h00);
        @(negedge clk);
        level(1, 10); level(0, 10); level(1, 10); level(0, 20);
        chk_reg("R11 disabled count", 3'd6, 0);
        chk_reg("R11 disabled status", 3'd1, 8'h00);
        tidy(32);
    endtask

    task automatic t_trigger;
        set_limit(1000);
        wr(3'd5, 8'd4);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h01);
        @(negedge clk);
        level(1, 1); level(0, 1); level(1, 1); level(0, 1); level(1, 1); level(0, 10);
        chk_reg("R8 count", 3'd6, 5);
        chk_reg("R8 threshold flag", 3'd1, 8'hC0);
        chk("R10 masked irq", int'(irq), 0);
        wr(3'd2, 8'h40);
        chk("R10 enabled irq", int'(irq), 1);
        wr(3'd1, 8'h40);
        chk("R10 irq after clear", int'(irq), 0);
        wr(3'd2, 8'h00);
        tidy(32);
    endtask

    task automatic t_overrun;
        set_limit(1000);
        wr(3'd5, 8'd0);
        wr(3'd0, 8'h01);
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            level(1, 1); level(0, 1);
        end
        level(0, 10);
        wr(3'd0, 8'h00);
        chk_reg("R7 count capped", 3'd6, 32);
        chk_reg("R7 overrun and ready", 3'd1, 8'h90);
        chk_reg("R7 oldest kept", 3'd7, 8'h81);
        wr(3'd5, 8'h80);
        chk_reg("R9 flushed", 3'd6, 0);
        tidy(32);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_basic;
        t_long_space;
        t_no_limit;
        t_invert;
        t_period;
        t_disabled;
        t_trigger;
        t_overrun;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule